// File: doc/BRIEF.md
# Open-Page Byte-Striped DRAM Controller

This block sits between a simple CPU-side request port and a module of eight byte-wide DRAM devices that together form one 64-bit word. Each device is a square grid of supercells with an internal row buffer. The controller splits a word address into a row index and a column index. It sends them one after the other on a shared narrow address bus. First comes a row strobe, which loads a row into every device's buffer. Then comes a column strobe, which reads or writes one supercell in each device. All eight devices receive the same row and column, and device k carries byte k of the word.

After a row strobe, the controller remembers which row is open. A later request to that same row skips the row phase and issues only a column strobe. Any other row, and the first request after reset, costs a full row phase first. The length of each strobe phase is set by a parameter.

Requests arrive through a valid/ready handshake. `req_ready` is high only while the controller is idle. A request presented while `req_ready` is low waits, and the requester must hold every request field stable until the accepting edge. Read data comes back as a one-cycle `rsp_valid` pulse and cannot be back-pressured: the requester must take it in the cycle it appears. Writes produce no response.

Top module: `dram_page_ctrl`

## Requirements
- R1: After reset, `mem_ras`, `mem_cas`, `mem_we` and `rsp_valid` are low, `req_ready` is high and no row counts as open, so the first request always runs a row phase, including a request to row 0.
- R2: A word address splits into row = upper ROW_BITS and column = lower COL_BITS. `mem_addr` carries the row throughout a row phase and the column throughout a column phase.
- R3: A request whose row differs from the open row, or that arrives with no row open, runs `mem_ras` high for exactly RAS_WAIT cycles, then the column phase.
- R4: A request to the open row runs no row phase: `mem_ras` stays low and the column phase starts in the cycle after acceptance.
- R5: A read raises `rsp_valid` for exactly one cycle, RAS_WAIT+CAS_WAIT cycles after the accepting edge on a row miss and CAS_WAIT cycles after it on a row hit. `rsp_rdata` then holds the word most recently written to that address.
- R6: A write holds `mem_cas` and `mem_we` high for exactly CAS_WAIT cycles, drives the request word on `mem_wdata` and produces no `rsp_valid`. A read never raises `mem_we`.
- R7: Byte k of a word (bits 8k+7 to 8k) travels on lane k of `mem_wdata`/`mem_rdata`, so device k stores exactly that byte at the shared row/column.
- R8: `req_ready` is high only when idle. It drops in the cycle after an accepting edge and rises again after the response cycle. While `req_valid` is low, no strobe is issued.
- R9: `mem_ras` and `mem_cas` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_BITS+COL_BITS | Word address, row in upper bits |
| req_wdata | input | LANES*LANE_W | Write word |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | LANES*LANE_W | Read word, zero when `rsp_valid` is low |
| mem_ras | output | 1 | Row strobe, active high |
| mem_cas | output | 1 | Column strobe, active high |
| mem_we | output | 1 | Column strobe writes when high |
| mem_addr | output | max(ROW_BITS,COL_BITS) | Shared row/column index |
| mem_wdata | output | LANES*LANE_W | Write lanes to the devices |
| mem_rdata | input | LANES*LANE_W | Read lanes from the devices |

## Verification
The properties assume that the devices place the selected supercell on `mem_rdata` at each column-strobe edge and hold it until the next one. They also assume that the requester keeps `req_valid` and the request fields steady until acceptance. The bench's device model follows that protocol exactly. Its driver raises `req_valid` only at falling edges, waits for `req_ready` and lowers the request right after the accepting edge. It mixes hits, misses, row 0 after reset and idle gaps, so every path through the sequencer is exercised without breaking those assumptions.

// File: rtl/dram_pc_pkg.sv
package dram_pc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_ROW    = 3'd1,
    PH_COL_RD = 3'd2,
    PH_COL_WR = 3'd3,
    PH_DONE   = 3'd4
  } phase_e;

  function automatic int unsigned larger_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dram_pc_addr_split.sv
module dram_pc_addr_split #(
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2
) (
  input  logic [ROW_BITS+COL_BITS-1:0] addr,
  input  logic [ROW_BITS-1:0]          open_row,
  input  logic                         open_vld,
  output logic [ROW_BITS-1:0]          row,
  output logic [COL_BITS-1:0]          col,
  output logic                         row_hit
);

  assign row     = addr[ROW_BITS+COL_BITS-1:COL_BITS];
  assign col     = addr[COL_BITS-1:0];
  assign row_hit = open_vld && (row == open_row);

endmodule

// File: rtl/dram_pc_row_tracker.sv
module dram_pc_row_tracker #(
  parameter int ROW_BITS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [ROW_BITS-1:0] load_row,
  output logic [ROW_BITS-1:0] open_row,
  output logic                open_vld
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_row <= '0;
      open_vld <= 1'b0;
    end else if (load) begin
      open_row <= load_row;
      open_vld <= 1'b1;
    end
  end

endmodule

// File: rtl/dram_pc_seq.sv
module dram_pc_seq
  import dram_pc_pkg::*;
#(
  parameter int RAS_WAIT = 2,
  parameter int CAS_WAIT = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  logic   req_write,
  input  logic   row_hit,
  output logic   req_ready,
  output logic   accept,
  output phase_e phase,
  output logic   row_load,
  output logic   rsp_fire
);

  localparam int CNT_W = $clog2(larger_of(RAS_WAIT, CAS_WAIT) + 1);
  localparam logic [CNT_W-1:0] ROW_LAST = CNT_W'(RAS_WAIT - 1);
  localparam logic [CNT_W-1:0] COL_LAST = CNT_W'(CAS_WAIT - 1);

  phase_e           state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dir_q, dir_d;

  assign req_ready = (state_q == PH_IDLE);
  assign accept    = req_ready && req_valid;
  assign phase     = state_q;
  assign row_load  = (state_q == PH_ROW) && (cnt_q == ROW_LAST);
  assign rsp_fire  = (state_q == PH_DONE) && !dir_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    dir_d   = dir_q;
    case (state_q)
      PH_IDLE: begin
        if (accept) begin
          dir_d = req_write;
          cnt_d = '0;
          if (row_hit) state_d = req_write ? PH_COL_WR : PH_COL_RD;
          else         state_d = PH_ROW;
        end
      end
      PH_ROW: begin
        if (cnt_q == ROW_LAST) begin
          cnt_d   = '0;
          state_d = dir_q ? PH_COL_WR : PH_COL_RD;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_COL_RD, PH_COL_WR: begin
        if (cnt_q == COL_LAST) begin
          cnt_d   = '0;
          state_d = PH_DONE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_DONE: state_d = PH_IDLE;
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
      dir_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      dir_q   <= dir_d;
    end
  end

endmodule

// File: rtl/dram_pc_lanes.sv
module dram_pc_lanes #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8
) (
  input  logic                    drive_wr,
  input  logic                    rsp_fire,
  input  logic [LANES*LANE_W-1:0] wdata_q,
  input  logic [LANES*LANE_W-1:0] mem_rdata,
  output logic [LANES*LANE_W-1:0] mem_wdata,
  output logic [LANES*LANE_W-1:0] rsp_rdata
);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign mem_wdata[k*LANE_W +: LANE_W] = drive_wr ? wdata_q[k*LANE_W +: LANE_W] : '0;
    assign rsp_rdata[k*LANE_W +: LANE_W] = rsp_fire ? mem_rdata[k*LANE_W +: LANE_W] : '0;
  end

endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
  import dram_pc_pkg::*;
#(
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2,
  parameter int LANES    = 8,
  parameter int LANE_W   = 8,
  parameter int RAS_WAIT = 2,
  parameter int CAS_WAIT = 2
) (
  input  logic                                                  clk,
  input  logic                                                  rst_n,
  input  logic                                                  req_valid,
  output logic                                                  req_ready,
  input  logic                                                  req_write,
  input  logic [ROW_BITS+COL_BITS-1:0]                          req_addr,
  input  logic [LANES*LANE_W-1:0]                               req_wdata,
  output logic                                                  rsp_valid,
  output logic [LANES*LANE_W-1:0]                               rsp_rdata,
  output logic                                                  mem_ras,
  output logic                                                  mem_cas,
  output logic                                                  mem_we,
  output logic [((ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS)-1:0] mem_addr,
  output logic [LANES*LANE_W-1:0]                               mem_wdata,
  input  logic [LANES*LANE_W-1:0]                               mem_rdata
);

  localparam int ADDR_W = ROW_BITS + COL_BITS;
  localparam int WORD_W = LANES * LANE_W;
  localparam int BUS_W  = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS;

  logic [ROW_BITS-1:0] in_row, row_q, open_row;
  logic [COL_BITS-1:0] in_col, col_q;
  logic                open_vld, row_hit;
  logic                accept, row_load, rsp_fire;
  logic [WORD_W-1:0]   wdata_q;
  phase_e              phase;

  dram_pc_addr_split #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_split (
    .addr     (req_addr),
    .open_row (open_row),
    .open_vld (open_vld),
    .row      (in_row),
    .col      (in_col),
    .row_hit  (row_hit)
  );

  dram_pc_row_tracker #(.ROW_BITS(ROW_BITS)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (row_load),
    .load_row (row_q),
    .open_row (open_row),
    .open_vld (open_vld)
  );

  dram_pc_seq #(.RAS_WAIT(RAS_WAIT), .CAS_WAIT(CAS_WAIT)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .row_hit   (row_hit),
    .req_ready (req_ready),
    .accept    (accept),
    .phase     (phase),
    .row_load  (row_load),
    .rsp_fire  (rsp_fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q   <= '0;
      col_q   <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      row_q   <= in_row;
      col_q   <= in_col;
      wdata_q <= req_wdata;
    end
  end

  always_comb begin
    mem_ras  = 1'b0;
    mem_cas  = 1'b0;
    mem_we   = 1'b0;
    mem_addr = '0;
    case (phase)
      PH_ROW: begin
        mem_ras  = 1'b1;
        mem_addr = BUS_W'(row_q);
      end
      PH_COL_RD: begin
        mem_cas  = 1'b1;
        mem_addr = BUS_W'(col_q);
      end
      PH_COL_WR: begin
        mem_cas  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = BUS_W'(col_q);
      end
      default: ;
    endcase
  end

  assign rsp_valid = rsp_fire;

  dram_pc_lanes #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
    .drive_wr  (phase == PH_COL_WR),
    .rsp_fire  (rsp_fire),
    .wdata_q   (wdata_q),
    .mem_rdata (mem_rdata),
    .mem_wdata (mem_wdata),
    .rsp_rdata (rsp_rdata)
  );

endmodule

// File: rtl/dram_page_ctrl_chk.sv
module dram_page_ctrl_chk #(
  parameter int BUS_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             mem_ras,
  input logic             mem_cas,
  input logic             mem_we,
  input logic [BUS_W-1:0] mem_addr
);

  // R9
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_ras && mem_cas));

  // R6
  write_only_in_column_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_cas);

  // R8
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R5
  response_after_column_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(mem_cas));

  // R2
  row_index_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ras && $past(mem_ras)) |-> $stable(mem_addr));

endmodule

bind dram_page_ctrl dram_page_ctrl_chk #(.BUS_W(BUS_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_ras   (mem_ras),
  .mem_cas   (mem_cas),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr)
);

// File: tb/test_dram_page_ctrl.sv
module test_dram_page_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int RW = 3;
  localparam int CW = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid;
  logic [63:0] rsp_rdata;
  logic        mem_ras, mem_cas, mem_we;
  logic [1:0]  mem_addr;
  logic [63:0] mem_wdata, mem_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_page_ctrl #(.RAS_WAIT(RW), .CAS_WAIT(CW)) i_dram_page_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_ras(mem_ras),
    .mem_cas(mem_cas), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Device model: eight byte-wide 4x4 devices sharing one address bus
  logic [7:0] cells [8][16];
  logic [7:0] rowbuf [8][4];
  logic [7:0] rd_q [8];
  logic [1:0] cur_row;

  always @(posedge clk) begin
    if (mem_ras) begin
      cur_row <= mem_addr;
      for (int k = 0; k < 8; k++)
        for (int c = 0; c < 4; c++) rowbuf[k][c] <= cells[k][{mem_addr, 2'(c)}];
    end
    if (mem_cas) begin
      for (int k = 0; k < 8; k++) begin
        if (mem_we) begin
          rowbuf[k][mem_addr] <= mem_wdata[k*8 +: 8];
          cells[k][{cur_row, mem_addr}] <= mem_wdata[k*8 +: 8];
        end else begin
          rd_q[k] <= rowbuf[k][mem_addr];
        end
      end
    end
  end

  always_comb
    for (int k = 0; k < 8; k++) mem_rdata[k*8 +: 8] = rd_q[k];

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int ras_cnt = 0;
  int we_cnt = 0;
  logic [1:0] seen_row = '0, seen_col = '0;
  logic [63:0] shadow [16];
  logic [63:0] exp_q [$];
  int          due_q [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bus observer and scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_ras) begin ras_cnt++; seen_row = mem_addr; end
      if (mem_cas) seen_col = mem_addr;
      if (mem_we && mem_cas) we_cnt++;
      if (rsp_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected response", 64'(rsp_rdata), 64'd0);
        end else begin
          logic [63:0] e;
          int d;
          e = exp_q.pop_front();
          d = due_q.pop_front();
          chk(rsp_rdata == e, "R5 read data", rsp_rdata, e);
          chk(cyc == d, "R5 response cycle", 64'(cyc), 64'(d));
        end
      end
    end
  end

  task automatic run(input bit wr, input logic [3:0] a, input logic [63:0] d, input bit miss);
    int ras0, we0, acc;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    ras0 = ras_cnt; we0 = we_cnt; acc = cyc + 1;
    if (wr) shadow[a] = d;
    else begin
      exp_q.push_back(shadow[a]);
      due_q.push_back(acc + (miss ? RW : 0) + CW);
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R8 ready low after accept", 64'(req_ready), 64'd0);
    while (!req_ready) @(negedge clk);
    if (miss) begin
      chk(ras_cnt - ras0 == RW, "R3 row phase length", 64'(ras_cnt - ras0), 64'(RW));
      chk(seen_row == a[3:2], "R2 row index", 64'(seen_row), 64'(a[3:2]));
    end else begin
      chk(ras_cnt == ras0, "R4 no row phase on hit", 64'(ras_cnt - ras0), 64'd0);
    end
    chk(we_cnt - we0 == (wr ? CW : 0), "R6 write strobe cycles", 64'(we_cnt - we0), 64'(wr ? CW : 0));
    chk(seen_col == a[1:0], "R2 column index", 64'(seen_col), 64'(a[1:0]));
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) shadow[i] = '0;
    for (int k = 0; k < 8; k++) begin
      rd_q[k] = '0;
      for (int c = 0; c < 16; c++) cells[k][c] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready && !mem_ras && !mem_cas && !mem_we && !rsp_valid, "R1 reset outputs",
        64'({req_ready, mem_ras, mem_cas, mem_we, rsp_valid}), 64'b10000);
    // R1 first access to row 0 still runs a row phase
    run(1'b1, 4'h1, 64'h0706050403020100, 1'b1);
    // R7 lane k holds byte k
    for (int k = 0; k < 8; k++)
      chk(cells[k][1] == 8'(k), "R7 lane byte", 64'(cells[k][1]), 64'(k));
    run(1'b0, 4'h1, '0, 1'b0);                        // R4 hit read
    run(1'b1, 4'h2, 64'hdeadbeef_cafef00d, 1'b0);     // R4 hit write
    run(1'b1, 4'hE, 64'h1122334455667788, 1'b1);      // R3 miss to row 3
    for (int k = 0; k < 8; k++)
      chk(cells[k][14] == 8'(64'h1122334455667788 >> (8*k)), "R7 lane byte row 3",
          64'(cells[k][14]), 64'(8'(64'h1122334455667788 >> (8*k))));
    run(1'b0, 4'hE, '0, 1'b0);
    run(1'b0, 4'h2, '0, 1'b1);                        // back to row 0: miss
    run(1'b0, 4'h0, '0, 1'b0);                        // unwritten cell reads zero
    run(1'b0, 4'h5, '0, 1'b1);
    // R8 idle gap: no strobes, no response
    begin
      int r0;
      r0 = ras_cnt;
      repeat (6) @(negedge clk);
      chk(ras_cnt == r0 && !mem_cas, "R8 idle no strobe", 64'(ras_cnt - r0), 64'd0);
    end
    run(1'b1, 4'h6, 64'hffff0000aaaa5555, 1'b0);
    run(1'b0, 4'h6, '0, 1'b0);
    run(1'b0, 4'hE, '0, 1'b1);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all reads answered", 64'(exp_q.size()), 64'd0);
    finish_run();
  end

endmodule